// File: doc/BRIEF.md
# Address Bit 20 Gate and Processor Reset Controller

This glue block sits between the processor and the system bus. It passes the processor's address bit 20 to the bus only while a gate-enable flag is set. While the flag is clear, the bus bit is held low. Every odd megabyte then folds onto the even megabyte below it, which reproduces the 1 MB wraparound of older 20-bit machines. Software sets or clears the flag by writing an I/O port.

The block also produces the processor reset pulse, and three sources can start it:

- **Shutdown cycle:** a shutdown cycle observed on the bus status lines.
- **Fast-reset port:** a write to a dedicated fast-reset port.
- **Command port:** a reset command written to a command port. This path is slower and fires only after a programmable delay, to model the latency of a controller-mediated reset.

Every pulse has the same fixed length. A trigger that arrives while a pulse is already running is dropped.

The gate flag is cleared only by the system power-on reset. A processor reset leaves it unchanged.

Top module: `a20_reset_ctl`

## Requirements
- R1: While the gate flag is 1, `busA20` equals `cpuA20` in the same cycle. The flag takes bit 0 of the data from an I/O write to `GATE_PORT` (default 16'h0090) and updates at the clock edge that samples the write.
- R2: While the gate flag is 0, `busA20` is 0 whatever `cpuA20` is. A write to `GATE_PORT` whose data bit 0 is 0 clears the flag.
- R3: While `sysRstN` is low at a clock edge, the gate flag, the command delay and the reset pulse are all cleared. After that edge, `busA20` is 0 and `cpuReset` is 0.
- R4: If `busStatus` equals `SHUTDOWN_CODE` (default 3'b101) at a clock edge and no pulse is running, `cpuReset` rises right after that edge.
- R5: An I/O write to `FAST_PORT` (default 16'h0094) with data bit 0 equal to 1 starts a pulse right after the sampling edge. The same write with bit 0 equal to 0 has no effect.
- R6: An I/O write of `RESET_CMD` (default 8'hFE) to `CMD_PORT` (default 16'h0098) raises `cpuReset` exactly `CMD_DELAY` cycles after the sampling edge. Any other data byte written to that port has no effect.
- R7: Every pulse lasts exactly `PULSE_LEN` cycles. Triggers that arrive while a pulse is running neither lengthen it nor queue a second pulse.
- R8: The gate flag keeps its value through a processor reset pulse.
- R9: Cycles without `ioWrEn`, and writes to any other address, change neither the gate flag nor the reset output.
- R10: A reset command written while an earlier command's delay is still counting is ignored. The reset then comes at the time set by the first command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| sysRstN | input | 1 | Power-on reset, active low, synchronous |
| cpuA20 | input | 1 | Address bit 20 driven by the processor |
| ioWrEn | input | 1 | I/O write strobe, one cycle per write |
| ioAddr | input | 16 | I/O write address |
| ioData | input | 8 | I/O write data |
| busStatus | input | 3 | Bus cycle status code from the processor |
| busA20 | output | 1 | Gated address bit 20 to the system bus |
| cpuReset | output | 1 | Reset pulse to the processor, active high |

## Verification
The results arrive at different times, and each check samples at the time its result is due:

- **Gated bit:** `busA20` is combinational from the gate flag. A gate write becomes visible right after the edge that samples it, so each table vector is checked just after the following rising edge.
- **Fast and shutdown triggers:** these raise `cpuReset` one edge after the trigger.
- **Command trigger:** this raises `cpuReset` exactly `CMD_DELAY` edges after the write.
- **Timing of the pulse:** the bench counts falling-edge samples. It measures the delay to the rising edge of `cpuReset` and how long the pulse stays high, and compares both with the cycle counts that the requirements give.

// File: rtl/a20rst_pkg.sv
package a20rst_pkg;

  // Strobes from the control decoder to the datapath, valid for one cycle.
  typedef struct packed {
    logic gateWr;   // write to the gate register
    logic gateVal;  // value to be written
    logic fastRst;  // fast-reset request
    logic cmdRst;   // reset command accepted on the command port
    logic shutRst;  // shutdown bus cycle seen
  } a20_strobe_t;

endpackage

// File: rtl/a20rst_ctrl.sv
module a20rst_ctrl
  import a20rst_pkg::*;
#(
  parameter logic [15:0] GATE_PORT     = 16'h0090,
  parameter logic [15:0] FAST_PORT     = 16'h0094,
  parameter logic [15:0] CMD_PORT      = 16'h0098,
  parameter logic [7:0]  RESET_CMD     = 8'hFE,
  parameter logic [2:0]  SHUTDOWN_CODE = 3'b101
) (
  input  logic        ioWrEn,
  input  logic [15:0] ioAddr,
  input  logic [7:0]  ioData,
  input  logic [2:0]  busStatus,
  output a20_strobe_t strobe
);

  logic hitGate;
  logic hitFast;
  logic hitCmd;

  assign hitGate = ioWrEn && (ioAddr == GATE_PORT);
  assign hitFast = ioWrEn && (ioAddr == FAST_PORT);
  assign hitCmd  = ioWrEn && (ioAddr == CMD_PORT);

  always_comb begin
    strobe.gateWr  = hitGate;
    strobe.gateVal = ioData[0];
    strobe.fastRst = hitFast && ioData[0];
    strobe.cmdRst  = hitCmd && (ioData == RESET_CMD);
    strobe.shutRst = (busStatus == SHUTDOWN_CODE);
  end

endmodule

// File: rtl/a20rst_dp.sv
module a20rst_dp
  import a20rst_pkg::*;
#(
  parameter int PULSE_LEN = 16,
  parameter int CMD_DELAY = 400
) (
  input  logic        clk,
  input  logic        sysRstN,
  input  a20_strobe_t strobe,
  input  logic        cpuA20,
  output logic        busA20,
  output logic        cpuReset
);

  localparam int PULSE_W = $clog2(PULSE_LEN + 1);
  localparam int DLY_W   = $clog2(CMD_DELAY + 1);

  logic               gateEn;
  logic [PULSE_W-1:0] pulseCnt;
  logic [DLY_W-1:0]   delayCnt;
  logic               cmdFire;
  logic               anyTrig;
  logic               pulseIdle;

  // Gate flag: cleared only by the power-on reset.
  always_ff @(posedge clk) begin
    if (!sysRstN) begin
      gateEn <= 1'b0;
    end else if (strobe.gateWr) begin
      gateEn <= strobe.gateVal;
    end
  end

  assign busA20 = cpuA20 & gateEn;

  // Command path: a delay counter that fires on its last count.
  assign cmdFire = (delayCnt == DLY_W'(1));

  always_ff @(posedge clk) begin
    if (!sysRstN) begin
      delayCnt <= '0;
    end else if (delayCnt != '0) begin
      delayCnt <= delayCnt - DLY_W'(1);
    end else if (strobe.cmdRst) begin
      delayCnt <= DLY_W'(CMD_DELAY);
    end
  end

  // Pulse generator: a trigger is accepted only while idle.
  assign pulseIdle = (pulseCnt == '0);
  assign anyTrig   = strobe.fastRst | strobe.shutRst | cmdFire;

  always_ff @(posedge clk) begin
    if (!sysRstN) begin
      pulseCnt <= '0;
    end else if (!pulseIdle) begin
      pulseCnt <= pulseCnt - PULSE_W'(1);
    end else if (anyTrig) begin
      pulseCnt <= PULSE_W'(PULSE_LEN);
    end
  end

  assign cpuReset = !pulseIdle;

endmodule

// File: rtl/a20_reset_ctl.sv
module a20_reset_ctl
  import a20rst_pkg::*;
#(
  parameter int          PULSE_LEN     = 16,
  parameter int          CMD_DELAY     = 400,
  parameter logic [15:0] GATE_PORT     = 16'h0090,
  parameter logic [15:0] FAST_PORT     = 16'h0094,
  parameter logic [15:0] CMD_PORT      = 16'h0098,
  parameter logic [7:0]  RESET_CMD     = 8'hFE,
  parameter logic [2:0]  SHUTDOWN_CODE = 3'b101
) (
  input  logic        clk,
  input  logic        sysRstN,
  input  logic        cpuA20,
  input  logic        ioWrEn,
  input  logic [15:0] ioAddr,
  input  logic [7:0]  ioData,
  input  logic [2:0]  busStatus,
  output logic        busA20,
  output logic        cpuReset
);

  a20_strobe_t strobe;

  a20rst_ctrl #(
    .GATE_PORT    (GATE_PORT),
    .FAST_PORT    (FAST_PORT),
    .CMD_PORT     (CMD_PORT),
    .RESET_CMD    (RESET_CMD),
    .SHUTDOWN_CODE(SHUTDOWN_CODE)
  ) u_ctrl (
    .ioWrEn   (ioWrEn),
    .ioAddr   (ioAddr),
    .ioData   (ioData),
    .busStatus(busStatus),
    .strobe   (strobe)
  );

  a20rst_dp #(
    .PULSE_LEN(PULSE_LEN),
    .CMD_DELAY(CMD_DELAY)
  ) u_dp (
    .clk     (clk),
    .sysRstN (sysRstN),
    .strobe  (strobe),
    .cpuA20  (cpuA20),
    .busA20  (busA20),
    .cpuReset(cpuReset)
  );

endmodule

// File: rtl/a20_reset_chk.sv
module a20_reset_chk #(
  parameter int          PULSE_LEN     = 16,
  parameter logic [15:0] FAST_PORT     = 16'h0094,
  parameter logic [2:0]  SHUTDOWN_CODE = 3'b101
) (
  input logic        clk,
  input logic        sysRstN,
  input logic        cpuA20,
  input logic        ioWrEn,
  input logic [15:0] ioAddr,
  input logic [7:0]  ioData,
  input logic [2:0]  busStatus,
  input logic        busA20,
  input logic        cpuReset
);

  logic [31:0] hiCnt;

  always_ff @(posedge clk) begin
    if (!sysRstN || !cpuReset) begin
      hiCnt <= '0;
    end else begin
      hiCnt <= hiCnt + 32'd1;
    end
  end

  assert_bus_needs_cpu_R1: assert property (@(posedge clk) disable iff (!sysRstN)
    busA20 |-> cpuA20);

  assert_reset_clears_R3: assert property (@(posedge clk)
    !sysRstN |=> !cpuReset);

  assert_shutdown_pulse_R4: assert property (@(posedge clk) disable iff (!sysRstN)
    (busStatus == SHUTDOWN_CODE && !cpuReset) |=> cpuReset);

  assert_fast_pulse_R5: assert property (@(posedge clk) disable iff (!sysRstN)
    (ioWrEn && ioAddr == FAST_PORT && ioData[0] && !cpuReset) |=> cpuReset);

  assert_pulse_max_R7: assert property (@(posedge clk) disable iff (!sysRstN)
    cpuReset |-> (hiCnt < 32'(PULSE_LEN)));

  assert_pulse_full_R7: assert property (@(posedge clk) disable iff (!sysRstN)
    (!cpuReset && $past(cpuReset) && $past(sysRstN)) |-> ($past(hiCnt) == 32'(PULSE_LEN - 1)));

endmodule

bind a20_reset_ctl a20_reset_chk #(
  .PULSE_LEN    (PULSE_LEN),
  .FAST_PORT    (FAST_PORT),
  .SHUTDOWN_CODE(SHUTDOWN_CODE)
) u_chk (
  .clk      (clk),
  .sysRstN  (sysRstN),
  .cpuA20   (cpuA20),
  .ioWrEn   (ioWrEn),
  .ioAddr   (ioAddr),
  .ioData   (ioData),
  .busStatus(busStatus),
  .busA20   (busA20),
  .cpuReset (cpuReset)
);

// File: tb/tb_a20_reset_ctl.sv
module tb_a20_reset_ctl;

  localparam int          CLK_PERIOD = 10;
  localparam int          PLEN       = 6;
  localparam int          CDLY       = 30;
  localparam logic [15:0] GATE_A     = 16'h0090;
  localparam logic [15:0] FAST_A     = 16'h0094;
  localparam logic [15:0] CMD_A      = 16'h0098;
  localparam logic [2:0]  SHUT       = 3'b101;

  logic        clk = 1'b0;
  logic        sysRstN = 1'b0;
  logic        cpuA20 = 1'b0;
  logic        ioWrEn = 1'b0;
  logic [15:0] ioAddr = '0;
  logic [7:0]  ioData = '0;
  logic [2:0]  busStatus = 3'b000;
  logic        busA20;
  logic        cpuReset;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  a20_reset_ctl #(.PULSE_LEN(PLEN), .CMD_DELAY(CDLY)) dut (
    .clk(clk), .sysRstN(sysRstN), .cpuA20(cpuA20), .ioWrEn(ioWrEn),
    .ioAddr(ioAddr), .ioData(ioData), .busStatus(busStatus),
    .busA20(busA20), .cpuReset(cpuReset)
  );

  // Vector fields: {req[3:0], wr, addr[15:0], data[7:0], a20, expected}
  localparam int NV = 10;
  localparam logic [30:0] VEC [NV] = '{
    {4'd1, 1'b1, GATE_A,   8'h01, 1'b1, 1'b1},  // R1 enable and pass
    {4'd1, 1'b0, GATE_A,   8'h00, 1'b0, 1'b0},  // R1 follows low
    {4'd1, 1'b0, 16'h0000, 8'h00, 1'b1, 1'b1},  // R1 follows high
    {4'd2, 1'b1, GATE_A,   8'h00, 1'b1, 1'b0},  // R2 disable forces low
    {4'd2, 1'b0, 16'h0000, 8'h00, 1'b1, 1'b0},  // R2 stays low
    {4'd9, 1'b1, 16'h0091, 8'h01, 1'b1, 1'b0},  // R9 other address
    {4'd9, 1'b0, GATE_A,   8'h01, 1'b1, 1'b0},  // R9 no strobe
    {4'd1, 1'b1, GATE_A,   8'hFF, 1'b1, 1'b1},  // R1 bit0 set in FF
    {4'd2, 1'b1, GATE_A,   8'hFE, 1'b1, 1'b0},  // R2 bit0 clear in FE
    {4'd1, 1'b1, GATE_A,   8'h01, 1'b1, 1'b1}   // R1 re-enable
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ioWrite(input logic [15:0] a, input logic [7:0] d);
    ioWrEn = 1'b1; ioAddr = a; ioData = d;
    @(negedge clk);
    ioWrEn = 1'b0; ioAddr = '0; ioData = '0;
  endtask

  task automatic shutdownCycle();
    busStatus = SHUT;
    @(negedge clk);
    busStatus = 3'b000;
  endtask

  task automatic measure(output int dly, output int len);
    dly = 0; len = 0;
    while (!cpuReset && dly < 500) begin dly++; @(negedge clk); end
    while (cpuReset && len < 500) begin len++; @(negedge clk); end
  endtask

  task automatic quiet(input int n, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (cpuReset) seen = 1'b1;
      @(negedge clk);
    end
  endtask

  initial begin
    int dly, len;
    bit seen;
    repeat (3) @(negedge clk);
    cpuA20 = 1'b1;
    @(negedge clk);
    // R3 state after power-on reset
    check(busA20 == 1'b0, "R3 busA20 in reset", busA20, 0);
    check(cpuReset == 1'b0, "R3 cpuReset in reset", cpuReset, 0);
    sysRstN = 1'b1;
    @(negedge clk);
    check(busA20 == 1'b0, "R3 gate clear after reset", busA20, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ioWrEn = VEC[i][26]; ioAddr = VEC[i][25:10]; ioData = VEC[i][9:2];
      cpuA20 = VEC[i][1];
      @(posedge clk); #1;
      if (busA20 !== VEC[i][0]) begin
        errors++;
        $display("FAIL R%0d vector %0d actual=%0d expected=%0d", VEC[i][30:27], i, busA20, VEC[i][0]);
      end
      checks++;
    end
    @(negedge clk);
    ioWrEn = 1'b0; ioAddr = '0; ioData = '0;
    @(negedge clk);

    // R9 writes elsewhere do not reset
    ioWrite(16'h0095, 8'h01);
    quiet(10, seen);
    check(!seen, "R9 stray write no reset", seen, 0);

    // R4 shutdown cycle
    shutdownCycle();
    measure(dly, len);
    check(dly == 0, "R4 shutdown delay", dly, 0);
    check(len == PLEN, "R4/R7 shutdown length", len, PLEN);

    // R5 fast port
    ioWrite(FAST_A, 8'h01);
    measure(dly, len);
    check(dly == 0, "R5 fast delay", dly, 0);
    check(len == PLEN, "R5/R7 fast length", len, PLEN);
    ioWrite(FAST_A, 8'h00);
    quiet(8, seen);
    check(!seen, "R5 bit0 clear no reset", seen, 0);

    // R8 gate survives processor reset (gate was left enabled)
    cpuA20 = 1'b1;
    check(busA20 == 1'b1, "R8 gate after pulses", busA20, 1);

    // R7 overlapping triggers do not lengthen
    ioWrite(FAST_A, 8'h01);
    len = 0;
    for (int i = 0; i < 40; i++) begin
      if (cpuReset) len++;
      busStatus = (i == 2 || i == PLEN - 1) ? SHUT : 3'b000;
      if (i == 3) begin ioWrEn = 1'b1; ioAddr = FAST_A; ioData = 8'h01; end
      else begin ioWrEn = 1'b0; ioAddr = '0; ioData = '0; end
      @(negedge clk);
      if (i == PLEN - 1) begin
        busStatus = 3'b000;
      end
    end
    // The shutdown at i == PLEN-1 lands on the last high cycle: dropped.
    check(len == PLEN, "R7 overlap length", len, PLEN);

    // R6 command delay
    ioWrite(CMD_A, 8'hFE);
    measure(dly, len);
    check(dly == CDLY, "R6 command delay", dly, CDLY);
    check(len == PLEN, "R6/R7 command length", len, PLEN);
    ioWrite(CMD_A, 8'h12);
    quiet(CDLY + 8, seen);
    check(!seen, "R6 other code ignored", seen, 0);

    // R10 second command during delay ignored
    ioWrite(CMD_A, 8'hFE);
    repeat (10) @(negedge clk);
    ioWrite(CMD_A, 8'hFE);
    measure(dly, len);
    check(dly == CDLY - 11, "R10 first command timing", dly, CDLY - 11);
    quiet(CDLY + 5, seen);
    check(!seen, "R10 no second pulse", seen, 0);

    // R3 power-on reset mid-pulse clears gate and pulse
    ioWrite(FAST_A, 8'h01);
    check(cpuReset == 1'b1, "R5 pulse running", cpuReset, 1);
    sysRstN = 1'b0;
    @(negedge clk);
    sysRstN = 1'b1;
    check(cpuReset == 1'b0, "R3 pulse cleared", cpuReset, 0);
    check(busA20 == 1'b0, "R3 gate cleared", busA20, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule